// File: doc/BRIEF.md
# Programmable Clock Output Skew Controller

This block derives several output clocks from one fast base clock. An integer divider sets their frequency. Each output edge can be moved in steps of a unit delay.

In fine mode a unit is one base tick. In coarse mode the divider advances only on every second tick, so a unit is two ticks. Halving the divide value in coarse mode keeps the output frequency unchanged.

A global feedback setting is subtracted from every output setting, so an output can lead the alignment reference (`refAlign`). Each output pair is either:
- a differential pair, where one setting drives the true output and the complement output, or
- two single-ended outputs, each with its own setting.

A bypass input routes the external reference straight to the outputs and ignores all skew settings.

Internally the divided clock runs through one tapped delay line. The alignment reference is taken a fixed 15 units down the line. Each output is taken 15 − feedback + setting units down the line, so every physical delay is non-negative while the delay relative to the reference can be negative.

Top module: `clk_skew_gen`

## Requirements
- R1: While `rstN` is low at a rising clock edge, `outP`, `outN` and `refAlign` are all 0 after that edge.
- R2: In fine mode (`coarse`=0), a rising edge of an output occurs exactly (setting − `fbSkew`) ticks after the rising edge of `refAlign`.
- R3: In coarse mode (`coarse`=1), the divider advances on every second tick, so the `refAlign` period is 2×`divVal` ticks. The rising-edge offset of an output relative to `refAlign` is 2×(setting − `fbSkew`) ticks.
- R4: When an output setting is below `fbSkew`, that output's rising edge comes before the rising edge of `refAlign`, by the magnitude given in R2 or R3.
- R5: In fine mode with an even `divVal`, `refAlign` has a period of `divVal` ticks and stays high for `divVal`/2 ticks. `divVal` must be at least 2.
- R6: Setting `diffMode[p]`=1 makes pair p differential. Slot 2p (bits [8p+3:8p] of `skewSet`) sets the skew of `outP[p]`, and `outN[p]` is the inverse of `outP[p]` on every tick.
- R7: Setting `diffMode[p]`=0 makes pair p single-ended. `outP[p]` takes slot 2p and `outN[p]` takes slot 2p+1 (bits [8p+7:8p+4]), each timed independently as in R2/R3.
- R8: While `bypass` is 1, the outputs follow `refIn` one tick later and all skew settings are ignored. `refAlign` and `outP` equal the previous `refIn`. `outN[p]` equals its inverse for a differential pair and equals it for a single-ended pair.
- R9: `divVal`, `coarse`, `fbSkew`, `skewSet` and `diffMode` are captured only at the start of a divider period. A change made in the middle of a period leaves the length of that period unchanged and applies from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one period is one tick |
| rstN | input | 1 | Synchronous active-low reset |
| refIn | input | 1 | External reference used in bypass |
| bypass | input | 1 | 1 routes `refIn` to all outputs |
| coarse | input | 1 | 1 selects the two-tick unit delay |
| divVal | input | DIV_W | Divide value, counted in divider steps |
| fbSkew | input | SKEW_W | Feedback skew, subtracted from every setting |
| skewSet | input | 2·NUM_PAIRS·SKEW_W | Per-output skew slots |
| diffMode | input | NUM_PAIRS | Per-pair differential select |
| outP | output | NUM_PAIRS | True / first output of each pair |
| outN | output | NUM_PAIRS | Complement / second output of each pair |
| refAlign | output | 1 | Alignment reference, 15 units down the line |

## Verification
The hardest situation to reach from the ports is a configuration change that lands strictly inside a divider period. The period start is internal and sits some ticks ahead of any visible edge.

The bench works back from a `refAlign` rise, which trails the internal period start by a known fixed latency. It changes `divVal` five ticks after that rise, which is well inside the running period. It then checks that the next interval keeps the old length and the one after takes the new length.

Negative offsets are also awkward to observe. Each offset is measured in a window that opens 30 ticks before a `refAlign` rise, and the settings are swept so that every feedback value meets smaller, equal and larger output settings in both unit sizes.

// File: rtl/clk_skew_pkg.sv
package clk_skew_pkg;

  // Strobes from the control side to the datapath side.
  typedef struct packed {
    logic stepEn;       // divider advances on this tick
    logic periodStart;  // last step of a divider period; config capture
  } skewStrobes_t;

endpackage

// File: rtl/clk_skew_ctrl.sv
module clk_skew_ctrl
  import clk_skew_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int SKEW_W    = 4,
  parameter int DIV_W     = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              coarseIn,
  input  logic [DIV_W-1:0]                  divValIn,
  input  logic [SKEW_W-1:0]                 fbSkewIn,
  input  logic [2*NUM_PAIRS*SKEW_W-1:0]     skewSetIn,
  input  logic [NUM_PAIRS-1:0]              diffModeIn,
  output skewStrobes_t                      strobes,
  output logic                              divClk,
  output logic                              cfgCoarse,
  output logic [SKEW_W-1:0]                 cfgFb,
  output logic [2*NUM_PAIRS*SKEW_W-1:0]     cfgSet,
  output logic [NUM_PAIRS-1:0]              cfgDiff
);

  logic             preTog;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cfgDiv;
  logic             loadCfg;

  // Coarse mode: the prescaler toggles and the divider steps every other tick.
  always_ff @(posedge clk) begin
    if (!rstN) preTog <= 1'b0;
    else       preTog <= cfgCoarse ? ~preTog : 1'b0;
  end

  always_comb begin
    strobes.stepEn      = cfgCoarse ? preTog : 1'b1;
    strobes.periodStart = strobes.stepEn && (cnt == cfgDiv - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             cnt <= '0;
    else if (strobes.stepEn) cnt <= strobes.periodStart ? '0 : cnt + 1'b1;
  end

  // Shadow registers: track the inputs in reset, then load only at a period boundary.
  assign loadCfg = !rstN || strobes.periodStart;

  always_ff @(posedge clk) begin
    if (loadCfg) begin
      cfgDiv    <= divValIn;
      cfgCoarse <= coarseIn;
      cfgFb     <= fbSkewIn;
      cfgSet    <= skewSetIn;
      cfgDiff   <= diffModeIn;
    end
  end

  // High for the first half of the count; 50 % duty for even divide values.
  assign divClk = (cnt < (cfgDiv >> 1));

endmodule

// File: rtl/clk_skew_dp.sv
module clk_skew_dp #(
  parameter int NUM_PAIRS = 2,
  parameter int SKEW_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          divClk,
  input  logic                          refIn,
  input  logic                          bypass,
  input  logic                          cfgCoarse,
  input  logic [SKEW_W-1:0]             cfgFb,
  input  logic [2*NUM_PAIRS*SKEW_W-1:0] cfgSet,
  input  logic [NUM_PAIRS-1:0]          cfgDiff,
  output logic [NUM_PAIRS-1:0]          outP,
  output logic [NUM_PAIRS-1:0]          outN,
  output logic                          refAlign
);

  localparam int MAX_SET = (1 << SKEW_W) - 1;
  localparam int MAX_TAP = 4 * MAX_SET;           // two units of offset range, two ticks each
  localparam int TAP_W   = $clog2(MAX_TAP + 1);

  logic [MAX_TAP:1] dl;
  logic [MAX_TAP:0] tapVec;

  // Shared delay line of the divided clock; tap k is k ticks late.
  always_ff @(posedge clk) begin
    if (!rstN) dl <= '0;
    else       dl <= {dl[MAX_TAP-1:1], divClk};
  end

  assign tapVec = {dl, divClk};

  // Physical tap = (MAX_SET - feedback + setting) units; always non-negative.
  function automatic logic [TAP_W-1:0] tapIndex(input logic [SKEW_W-1:0] setV,
                                                input logic [SKEW_W-1:0] fbV,
                                                input logic              crs);
    logic [SKEW_W+1:0] units;
    units = (SKEW_W+2)'(MAX_SET) - {2'b00, fbV} + {2'b00, setV};
    return crs ? TAP_W'({units, 1'b0}) : TAP_W'(units);
  endfunction

  logic [TAP_W-1:0] refIdx;
  assign refIdx = tapIndex('0, '0, cfgCoarse);

  always_ff @(posedge clk) begin
    if (!rstN) refAlign <= 1'b0;
    else       refAlign <= bypass ? refIn : tapVec[refIdx];
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [TAP_W-1:0] idxP;
    logic [TAP_W-1:0] idxN;
    logic             nextP;
    logic             nextN;

    assign idxP = tapIndex(cfgSet[(2*p)*SKEW_W +: SKEW_W], cfgFb, cfgCoarse);
    assign idxN = tapIndex(cfgSet[(2*p+1)*SKEW_W +: SKEW_W], cfgFb, cfgCoarse);

    always_comb begin
      if (bypass) begin
        nextP = refIn;
        nextN = cfgDiff[p] ? ~refIn : refIn;
      end else begin
        nextP = tapVec[idxP];
        nextN = cfgDiff[p] ? ~tapVec[idxP] : tapVec[idxN];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        outP[p] <= 1'b0;
        outN[p] <= 1'b0;
      end else begin
        outP[p] <= nextP;
        outN[p] <= nextN;
      end
    end
  end

endmodule

// File: rtl/clk_skew_gen.sv
module clk_skew_gen
  import clk_skew_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int SKEW_W    = 4,
  parameter int DIV_W     = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          refIn,
  input  logic                          bypass,
  input  logic                          coarse,
  input  logic [DIV_W-1:0]              divVal,
  input  logic [SKEW_W-1:0]             fbSkew,
  input  logic [2*NUM_PAIRS*SKEW_W-1:0] skewSet,
  input  logic [NUM_PAIRS-1:0]          diffMode,
  output logic [NUM_PAIRS-1:0]          outP,
  output logic [NUM_PAIRS-1:0]          outN,
  output logic                          refAlign
);

  skewStrobes_t                  strobes;
  logic                          divClk;
  logic                          cfgCoarse;
  logic [SKEW_W-1:0]             cfgFb;
  logic [2*NUM_PAIRS*SKEW_W-1:0] cfgSet;
  logic [NUM_PAIRS-1:0]          cfgDiff;

  clk_skew_ctrl #(.NUM_PAIRS(NUM_PAIRS), .SKEW_W(SKEW_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .coarseIn(coarse), .divValIn(divVal),
    .fbSkewIn(fbSkew), .skewSetIn(skewSet), .diffModeIn(diffMode),
    .strobes(strobes), .divClk(divClk), .cfgCoarse(cfgCoarse),
    .cfgFb(cfgFb), .cfgSet(cfgSet), .cfgDiff(cfgDiff)
  );

  clk_skew_dp #(.NUM_PAIRS(NUM_PAIRS), .SKEW_W(SKEW_W)) u_dp (
    .clk(clk), .rstN(rstN), .divClk(divClk), .refIn(refIn), .bypass(bypass),
    .cfgCoarse(cfgCoarse), .cfgFb(cfgFb), .cfgSet(cfgSet), .cfgDiff(cfgDiff),
    .outP(outP), .outN(outN), .refAlign(refAlign)
  );

endmodule

// File: rtl/clk_skew_chk.sv
module clk_skew_chk
  import clk_skew_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int SKEW_W    = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 refIn,
  input logic                 bypass,
  input logic [NUM_PAIRS-1:0] outP,
  input logic [NUM_PAIRS-1:0] outN,
  input logic                 refAlign,
  input skewStrobes_t         strobes,
  input logic                 cfgCoarse,
  input logic [SKEW_W-1:0]    cfgFb,
  input logic [NUM_PAIRS-1:0] cfgDiff
);

  AST_FINE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgCoarse && !strobes.periodStart) |=> strobes.stepEn); // R2

  AST_COARSE_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCoarse && strobes.stepEn && !strobes.periodStart) |=> !strobes.stepEn); // R3

  AST_BYPASS_REF: assert property (@(posedge clk) disable iff (!rstN)
    bypass |=> (refAlign == $past(refIn))); // R8

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.periodStart |=> ($stable(cfgFb) && $stable(cfgDiff))); // R9

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk
    AST_DIFF_COMPL: assert property (@(posedge clk) disable iff (!rstN)
      (!bypass && cfgDiff[p]) |=> (outN[p] == ~outP[p])); // R6
  end

endmodule

bind clk_skew_gen clk_skew_chk #(.NUM_PAIRS(NUM_PAIRS), .SKEW_W(SKEW_W)) u_chk (
  .clk(clk), .rstN(rstN), .refIn(refIn), .bypass(bypass), .outP(outP),
  .outN(outN), .refAlign(refAlign), .strobes(strobes), .cfgCoarse(cfgCoarse),
  .cfgFb(cfgFb), .cfgDiff(cfgDiff)
);

// File: tb/clk_skew_gen_tb.sv
`timescale 1ns/1ps
module clk_skew_gen_tb;
  localparam int NP = 2;
  localparam int SW = 4;
  localparam int DW = 8;
  localparam int NO = 2 * NP;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              refIn = 1'b0;
  logic              bypass = 1'b0;
  logic              coarse = 1'b0;
  logic [DW-1:0]     divVal = 8'd64;
  logic [SW-1:0]     fbSkew = '0;
  logic [NO*SW-1:0]  skewSet = '0;
  logic [NP-1:0]     diffMode = '0;
  logic [NP-1:0]     outP, outN;
  logic              refAlign;

  int nChk = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clk_skew_gen #(.NUM_PAIRS(NP), .SKEW_W(SW), .DIV_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .refIn(refIn), .bypass(bypass), .coarse(coarse),
    .divVal(divVal), .fbSkew(fbSkew), .skewSet(skewSet), .diffMode(diffMode),
    .outP(outP), .outN(outN), .refAlign(refAlign)
  );

  // Edge monitor: ticks counted on falling edges, away from the active edge.
  int tick = 0, refRises = 0, refRiseTick = 0, refFallTick = 0;
  int riseP [NP];
  int riseN [NP];
  logic prevRef = 1'b0;
  logic [NP-1:0] prevP = '0, prevN = '0;

  always @(negedge clk) begin
    tick++;
    if (refAlign && !prevRef) begin refRiseTick = tick; refRises++; end
    if (!refAlign && prevRef) refFallTick = tick;
    prevRef = refAlign;
    for (int p = 0; p < NP; p++) begin
      if (outP[p] && !prevP[p]) riseP[p] = tick;
      if (outN[p] && !prevN[p]) riseN[p] = tick;
    end
    prevP = outP;
    prevN = outN;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitRefRise(output int tr);
    int c0 = refRises;
    while (refRises == c0) @(posedge clk);
    tr = refRiseTick;
  endtask

  int setv [NO];

  task automatic loadSets();
    for (int i = 0; i < NO; i++) skewSet[i*SW +: SW] = SW'(setv[i]);
  endtask

  // Measure each output's rise relative to a refAlign rise and compare.
  task automatic measure(input int unitT, input bit diffP0);
    int tr;
    waitRefRise(tr);
    repeat (31) @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      int expP = (setv[2*p] - int'(fbSkew)) * unitT;
      int expN = (setv[2*p+1] - int'(fbSkew)) * unitT;
      string tagP = (expP < 0) ? "R4" : ((unitT == 2) ? "R3" : "R2");
      chk(riseP[p] - tr == expP, tagP, riseP[p] - tr, expP);
      if (!(diffP0 && p == 0))
        chk(riseN[p] - tr == expN, (expN < 0) ? "R4" : "R7", riseN[p] - tr, expN);
    end
  endtask

  initial begin
    int fbList [3] = '{0, 6, 15};
    int t0, t1, t2, bad;
    logic prevIn;
    for (int p = 0; p < NP; p++) begin riseP[p] = 0; riseN[p] = 0; end

    // R1: reset clears every output
    repeat (5) @(negedge clk);
    chk(refAlign == 1'b0, "R1", refAlign, 0);
    chk(outP == '0, "R1", outP, 0);
    chk(outN == '0, "R1", outN, 0);
    @(negedge clk) rstN = 1'b1;

    // R2/R3/R4/R7: sweep unit size, feedback and per-slot settings
    for (int c = 0; c < 2; c++)
      for (int fi = 0; fi < 3; fi++)
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          coarse = c[0];
          divVal = c ? 8'd32 : 8'd64;
          fbSkew = SW'(fbList[fi]);
          diffMode = '0;
          for (int i = 0; i < NO; i++) setv[i] = (k*5 + i*4 + fi*3) % 16;
          loadSets();
          repeat (260) @(posedge clk);
          measure(c ? 2 : 1, 1'b0);
        end

    // R3: coarse period length with half divide value
    waitRefRise(t0);
    waitRefRise(t1);
    chk(t1 - t0 == 64, "R3", t1 - t0, 64);

    // R5: fine period and duty
    @(negedge clk);
    coarse = 1'b0; divVal = 8'd64; fbSkew = 4'd3;
    setv = '{9, 1, 3, 12};
    loadSets();
    repeat (260) @(posedge clk);
    waitRefRise(t0);
    repeat (40) @(posedge clk);
    chk(refFallTick - t0 == 32, "R5", refFallTick - t0, 32);
    waitRefRise(t1);
    chk(t1 - t0 == 64, "R5", t1 - t0, 64);

    // R9: divide change mid-period applies only from the next period
    repeat (5) @(posedge clk);
    @(negedge clk) divVal = 8'd48;
    waitRefRise(t2);
    chk(t2 - t1 == 64, "R9", t2 - t1, 64);
    waitRefRise(t0);
    chk(t0 - t2 == 48, "R9", t0 - t2, 48);
    @(negedge clk) divVal = 8'd64;

    // R6: pair 0 differential
    diffMode = 2'b01;
    repeat (260) @(posedge clk);
    measure(1, 1'b1);
    bad = 0;
    for (int n = 0; n < 128; n++) begin
      @(negedge clk);
      if (outN[0] !== ~outP[0]) bad++;
    end
    chk(bad == 0, "R6", bad, 0);

    // R8: bypass follows refIn one tick later, settings ignored
    @(negedge clk) bypass = 1'b1;
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      prevIn = refIn;
      refIn = ((n * 7 + 3) % 5) > 1;
      @(negedge clk);
      chk(refAlign == refIn, "R8", refAlign, refIn);
      chk(outP == {NP{refIn}}, "R8", outP, {NP{refIn}});
      chk(outN[0] == ~refIn, "R8", outN[0], ~refIn);
      chk(outN[1] == refIn, "R8", outN[1], refIn);
      if (prevIn == refIn) chk(refAlign == prevIn, "R8", refAlign, prevIn);
    end
    @(negedge clk) bypass = 1'b0;

    // R1: reset in mid-run
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    chk(refAlign == 1'b0 && outP == '0 && outN == '0, "R1", {outP, outN, refAlign}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

endmodule